// File: doc/BRIEF.md
# Coprocessor Interrupt Request Gate

This block holds the interrupt-related fields of a processor control coprocessor's Status and Cause registers and turns them into one registered interrupt request for the pipeline. Software reaches it through two write ports, one for Status and one for Cause, and reads both registers back on two output buses. Six hardware interrupt lines come in as a bus. Together with two software-settable bits they form the eight-bit pending field.

The request is the AND of two terms. The first is a global enable term: the interrupt enable bit is set, neither exception level nor error level is active, the core is not in debug mode, and the running thread is not exempt from interrupts. The second is a pending term, and a mode input picks how it is formed. In mask mode, each pending bit is gated by its own mask bit. In level mode, an external vectoring controller drives a vector number into the pending field, and the mask field is read as a priority level. The vector must be strictly above that level.

Top module: `cp0_irq_gate`

## Requirements
- R1: After reset, status_rd reads 0x0000_0004: enable bit 0 is 0, exception-level bit 1 is 0, error-level bit 2 is 1, and the mask field at bits 15:8 is 0. The software pending bits are 0 and irq_req is 0.
- R2: A request needs the enable bit (Status bit 0) at 1 and the exception-level bit (Status bit 1) at 0. If either condition fails, irq_req stays 0.
- R3: The error-level bit (Status bit 2) at 1 blocks the request. So does dbg_mode at 1.
- R4: When MT_CAPABLE is nonzero, thr_exempt at 1 blocks the request.
- R5: With vec_ctl_mode at 0, the pending term is true exactly when the pending field (Cause bits 15:8) AND the mask field (Status bits 15:8) is nonzero.
- R6: With vec_ctl_mode at 1, both fields are unsigned 8-bit numbers, and the pending term is true exactly when pending is strictly greater than mask. An equal value gives no request.
- R7: irq_req is a register. After each rising edge it shows the enable AND pending result computed from the register contents and inputs that were present before that edge.
- R8: A Cause write changes only the software pending bits (Cause bits 9:8). Cause bits 15:10 always show hw_irq[5:0] as they are at that moment, and every other Cause bit reads 0.
- R9: A Status write loads bits 0, 1, 2 and 15:8. Every other Status bit reads 0, and the register holds its value when there is no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_we | input | 1 | Status write strobe |
| status_wdata | input | 32 | Status write data |
| cause_we | input | 1 | Cause write strobe |
| cause_wdata | input | 32 | Cause write data |
| hw_irq | input | 6 | Hardware interrupt lines, pending bits 7:2 |
| dbg_mode | input | 1 | Core is in debug mode |
| thr_exempt | input | 1 | Running thread is exempt from interrupts |
| vec_ctl_mode | input | 1 | 1 selects level comparison, 0 selects bitwise mask |
| status_rd | output | 32 | Status read value |
| cause_rd | output | 32 | Cause read value |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is in level mode, where the pending vector is built from two sources. The low two bits come from a Cause write and the upper six bits from the hardware lines. To land exactly on the mask level, or one step above or below it, the stimulus programs the level first and then sets the software bits and the hardware lines together. This is how it produces the equal-value case and the 0x80-over-0x7F case. Each blocking condition is also raised on its own, starting from a state that is otherwise requesting, so every condition is shown to block the request by itself.

// File: rtl/cp0_irq_pkg.sv
package cp0_irq_pkg;
  localparam int IE_POS    = 0;
  localparam int EXL_POS   = 1;
  localparam int ERL_POS   = 2;
  localparam int FIELD_LSB = 8;

  typedef enum logic {
    CMP_MASK  = 1'b0,
    CMP_LEVEL = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/cp0_irq_status.sv
module cp0_irq_status
  import cp0_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               ie,
  output logic               exl,
  output logic               erl,
  output logic [N_LINES-1:0] im,
  output logic [DATA_W-1:0]  rd_data
);
  logic               ie_q, exl_q, erl_q;
  logic               ie_d, exl_d, erl_d;
  logic [N_LINES-1:0] im_q, im_d;
  logic               unused_wbits;

  assign unused_wbits = ^wr_data;

  always_comb begin
    ie_d  = wr_data[IE_POS];
    exl_d = wr_data[EXL_POS];
    erl_d = wr_data[ERL_POS];
    im_d  = wr_data[FIELD_LSB +: N_LINES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      exl_q <= 1'b0;
      erl_q <= 1'b1;
      im_q  <= '0;
    end else if (wr_en) begin
      ie_q  <= ie_d;
      exl_q <= exl_d;
      erl_q <= erl_d;
      im_q  <= im_d;
    end
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[IE_POS]                = ie_q;
    rd_data[EXL_POS]               = exl_q;
    rd_data[ERL_POS]               = erl_q;
    rd_data[FIELD_LSB +: N_LINES]  = im_q;
  end

  assign ie  = ie_q;
  assign exl = exl_q;
  assign erl = erl_q;
  assign im  = im_q;

  // R9: no write leaves the readback unchanged
  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
  // R9: a write lands in the mask field
  p_status_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[FIELD_LSB +: N_LINES] == $past(wr_data[FIELD_LSB +: N_LINES])));
endmodule

// File: rtl/cp0_irq_cause.sv
module cp0_irq_cause
  import cp0_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_LINES = 8,
  parameter int N_SW    = 2,
  localparam int N_HW   = N_LINES - N_SW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [N_HW-1:0]    hw_lines,
  output logic [N_LINES-1:0] ip,
  output logic [DATA_W-1:0]  rd_data
);
  logic [N_SW-1:0] sw_q, sw_d;
  logic            unused_wbits;

  assign unused_wbits = ^wr_data;

  always_comb begin
    sw_d = wr_data[FIELD_LSB +: N_SW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
    end else if (wr_en) begin
      sw_q <= sw_d;
    end
  end

  assign ip = {hw_lines, sw_q};

  always_comb begin
    rd_data                       = '0;
    rd_data[FIELD_LSB +: N_LINES] = ip;
  end

  // R8: software bits only move on a Cause write
  p_sw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[FIELD_LSB +: N_SW]));
endmodule

// File: rtl/cp0_irq_decide.sv
module cp0_irq_decide
  import cp0_irq_pkg::*;
#(
  parameter int N_LINES    = 8,
  parameter int MT_CAPABLE = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ie,
  input  logic               exl,
  input  logic               erl,
  input  logic [N_LINES-1:0] im,
  input  logic [N_LINES-1:0] ip,
  input  logic               dbg_mode,
  input  logic               thr_exempt,
  input  cmp_mode_e          cmp_mode,
  output logic               irq_req
);
  logic exempt_eff;
  logic enable_t, pending_t, req_d, req_q;

  generate
    if (MT_CAPABLE != 0) begin : g_mt
      assign exempt_eff = thr_exempt;
    end else begin : g_no_mt
      logic unused_exempt;
      assign unused_exempt = thr_exempt;
      assign exempt_eff    = 1'b0;
    end
  endgenerate

  always_comb begin
    enable_t = ie && !exl && !erl && !dbg_mode && !exempt_eff;
    if (cmp_mode == CMP_LEVEL) pending_t = (ip > im);
    else                       pending_t = |(ip & im);
    req_d = enable_t && pending_t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign irq_req = req_q;

  // R2: exception level blocks
  p_exl_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exl |=> !irq_req);
  // R2: enable bit clear blocks
  p_ie_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |=> !irq_req);
  // R3: error level or debug mode block
  p_erl_dbg_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (erl || dbg_mode) |=> !irq_req);
  // R4: exempt thread blocks on multithreaded builds
  p_exempt_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((MT_CAPABLE != 0) && thr_exempt) |=> !irq_req);
  // R5: disjoint mask and pending give nothing in mask mode
  p_mask_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_mode == CMP_MASK) && ((ip & im) == '0)) |=> !irq_req);
  // R6: vector at or below level gives nothing in level mode
  p_level_not_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_mode == CMP_LEVEL) && (ip <= im)) |=> !irq_req);
endmodule

// File: rtl/cp0_irq_gate.sv
module cp0_irq_gate
  import cp0_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int N_LINES    = 8,
  parameter int N_SW       = 2,
  parameter int MT_CAPABLE = 1,
  localparam int N_HW      = N_LINES - N_SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              status_we,
  input  logic [DATA_W-1:0] status_wdata,
  input  logic              cause_we,
  input  logic [DATA_W-1:0] cause_wdata,
  input  logic [N_HW-1:0]   hw_irq,
  input  logic              dbg_mode,
  input  logic              thr_exempt,
  input  logic              vec_ctl_mode,
  output logic [DATA_W-1:0] status_rd,
  output logic [DATA_W-1:0] cause_rd,
  output logic              irq_req
);
  logic               st_ie, st_exl, st_erl;
  logic [N_LINES-1:0] st_im, ca_ip;
  cmp_mode_e          mode;

  assign mode = cmp_mode_e'(vec_ctl_mode);

  cp0_irq_status #(.DATA_W(DATA_W), .N_LINES(N_LINES)) u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(status_we), .wr_data(status_wdata),
    .ie(st_ie), .exl(st_exl), .erl(st_erl), .im(st_im), .rd_data(status_rd)
  );

  cp0_irq_cause #(.DATA_W(DATA_W), .N_LINES(N_LINES), .N_SW(N_SW)) u_cause (
    .clk(clk), .rst_n(rst_n), .wr_en(cause_we), .wr_data(cause_wdata),
    .hw_lines(hw_irq), .ip(ca_ip), .rd_data(cause_rd)
  );

  cp0_irq_decide #(.N_LINES(N_LINES), .MT_CAPABLE(MT_CAPABLE)) u_decide (
    .clk(clk), .rst_n(rst_n), .ie(st_ie), .exl(st_exl), .erl(st_erl),
    .im(st_im), .ip(ca_ip), .dbg_mode(dbg_mode), .thr_exempt(thr_exempt),
    .cmp_mode(mode), .irq_req(irq_req)
  );
endmodule

// File: tb/test_cp0_irq_gate.sv
`timescale 1ns/1ps
module test_cp0_irq_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        status_we = 1'b0, cause_we = 1'b0;
  logic [31:0] status_wdata = '0, cause_wdata = '0;
  logic [5:0]  hw_irq = '0;
  logic        dbg_mode = 1'b0, thr_exempt = 1'b0, vec_ctl_mode = 1'b0;
  logic [31:0] status_rd, cause_rd;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit       m_ie = 0, m_exl = 0, m_erl = 1, m_irq = 0;
  bit [7:0] m_im = 0;
  bit [1:0] m_sw = 0;

  always #2 clk = ~clk;

  cp0_irq_gate i_cp0_irq_gate (
    .clk(clk), .rst_n(rst_n), .status_we(status_we), .status_wdata(status_wdata),
    .cause_we(cause_we), .cause_wdata(cause_wdata), .hw_irq(hw_irq),
    .dbg_mode(dbg_mode), .thr_exempt(thr_exempt), .vec_ctl_mode(vec_ctl_mode),
    .status_rd(status_rd), .cause_rd(cause_rd), .irq_req(irq_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ie = 0; m_exl = 0; m_erl = 1; m_im = 0; m_sw = 0; m_irq = 0;
    end else begin
      bit [7:0] ipv;
      bit en, pend;
      ipv  = {hw_irq, m_sw};
      en   = m_ie && !m_exl && !m_erl && !dbg_mode && !thr_exempt;
      pend = vec_ctl_mode ? (ipv > m_im) : ((ipv & m_im) != 0);
      m_irq = en && pend;
      if (status_we) begin
        m_ie = status_wdata[0]; m_exl = status_wdata[1];
        m_erl = status_wdata[2]; m_im = status_wdata[15:8];
      end
      if (cause_we) m_sw = cause_wdata[9:8];
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R9 status model", status_rd, {16'h0, m_im, 5'h0, m_erl, m_exl, m_ie});
      check("R8 cause model", cause_rd, {16'h0, hw_irq, m_sw, 8'h0});
      check("R7 irq model", {31'h0, irq_req}, {31'h0, m_irq});
    end
  end

  task automatic wr_status(logic [31:0] v);
    @(negedge clk); #1;
    status_we = 1; status_wdata = v;
    @(negedge clk); #1;
    status_we = 0; status_wdata = 32'hDEAD_0000;
  endtask

  task automatic wr_cause(logic [31:0] v);
    @(negedge clk); #1;
    cause_we = 1; cause_wdata = v;
    @(negedge clk); #1;
    cause_we = 0; cause_wdata = 32'hBEEF_0000;
  endtask

  task automatic expect_irq(bit exp, string tag);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(tag, {31'h0, irq_req}, {31'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 reset status", status_rd, 32'h0000_0004);
    check("R1 reset cause", cause_rd, 32'h0);
    check("R1 reset irq", {31'h0, irq_req}, 32'h0);

    // enabled, mask mode, sw bit 0 pending
    wr_status(32'h0000_0101);
    wr_cause(32'h0000_0100);
    expect_irq(1, "R5 mask overlap requests");
    // R7 timing: clear sw bit, request drops one edge after register change
    @(negedge clk); #1 cause_we = 1; cause_wdata = 32'h0;
    @(negedge clk); #1 cause_we = 0;
    check("R7 irq still high one cycle", {31'h0, irq_req}, 32'h1);
    @(negedge clk);
    check("R7 irq low after register", {31'h0, irq_req}, 32'h0);
    wr_cause(32'h0000_0100);
    expect_irq(1, "R7 back high");

    wr_status(32'h0000_0103); expect_irq(0, "R2 exl blocks");
    wr_status(32'h0000_0100); expect_irq(0, "R2 ie clear blocks");
    wr_status(32'h0000_0105); expect_irq(0, "R3 erl blocks");
    wr_status(32'h0000_0101); expect_irq(1, "R2 re-enabled");
    @(negedge clk); #1 dbg_mode = 1;
    expect_irq(0, "R3 debug blocks");
    @(negedge clk); #1 dbg_mode = 0; thr_exempt = 1;
    expect_irq(0, "R4 exempt blocks");
    @(negedge clk); #1 thr_exempt = 0;
    expect_irq(1, "R4 exempt released");

    // mask mode disjoint, then hw line
    wr_status(32'h0000_0201); expect_irq(0, "R5 disjoint no request");
    wr_cause(32'h0); wr_status(32'h0000_0401);
    @(negedge clk); #1 hw_irq = 6'b000001;
    expect_irq(1, "R5 hw line with mask");
    @(negedge clk); #1 hw_irq = 6'b000010;
    expect_irq(0, "R5 hw line masked");

    // level mode
    @(negedge clk); #1 vec_ctl_mode = 1; hw_irq = 6'b000001;
    wr_status(32'h0000_0501);
    wr_cause(32'h0000_0200);                 // ip = 0x06
    expect_irq(1, "R6 above level");
    wr_cause(32'h0000_0100);                 // ip = 0x05
    expect_irq(0, "R6 equal level no request");
    wr_cause(32'h0000_0000);                 // ip = 0x04
    expect_irq(0, "R6 below level");
    wr_status(32'h0000_7F01);
    @(negedge clk); #1 hw_irq = 6'b100000;   // ip = 0x80
    expect_irq(1, "R6 unsigned 0x80 over 0x7F");
    wr_status(32'h0000_FF01);
    @(negedge clk); #1 hw_irq = 6'b111111;
    wr_cause(32'h0000_0300);                 // ip = 0xFF
    expect_irq(0, "R6 equal at top");

    // field isolation
    wr_cause(32'hFFFF_FCFF);
    @(negedge clk);
    check("R8 only sw bits written", cause_rd, 32'h0000_FC00);
    wr_status(32'hFFFF_FFFF);
    @(negedge clk);
    check("R9 unused status bits read 0", status_rd, 32'h0000_FF07);

    // random phase, compared by the model every cycle
    vec_ctl_mode = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      status_we = ($urandom % 6) == 0; status_wdata = $urandom;
      cause_we = ($urandom % 4) == 0;  cause_wdata = $urandom;
      hw_irq = $urandom; dbg_mode = ($urandom % 8) == 0;
      thr_exempt = ($urandom % 8) == 0; vec_ctl_mode = $urandom;
      if (status_we) status_wdata[2:0] = 3'b001;
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule